// File: doc/BRIEF.md
# Single-Bank DRAM Access Sequencer

This block sits between a simple request/response client and one DRAM bank. It takes one read or write at a time over a valid/ready handshake and turns it into a timed series of bank commands: open a row, access a column slice, and close the row. Commands go out as one-cycle strobes, and a shared address bus carries the row address when a row is opened and the column address when a column is accessed.

The sequencer uses an open-row policy. After a row is opened it stays open, and the sequencer remembers its number. A later request to the same row issues only the column command. A request to another row first closes the open row, then opens the new one. After reset no row is open, so the first request opens a row without a close before it. Each gap between commands is a parameter in clock cycles and is counted out by one shared down-counter.

Top module: `dram_bank_seq`

## Requirements
- R1: While reset is applied and afterwards until the first request, `reqReady` is 1, `rspValid` is 0 and no command strobe is active.
- R2: When no row is open (after reset), an accepted request opens a row in the cycle after acceptance. It issues no close command, and `dramAddr` carries the row field (upper `ROW_W` bits of `reqAddr`).
- R3: After a row open, the column command follows exactly `T_RCD` cycles later.
- R4: A request whose row field equals the open row issues its column command in the cycle after acceptance, with no open or close command.
- R5: A request to a row other than the open one issues a close command in the cycle after acceptance, and the open command exactly `T_RP` cycles after it. A row is never opened while another is open.
- R6: During a column command `dramAddr` carries the column field (lower `COL_W` bits of `reqAddr`), zero-extended.
- R7: For a read, `rspValid` is high for exactly one cycle, `T_CAS` cycles after the read command. In that cycle `rspRdata` holds the `SLICE_W`-bit slice stored at the addressed row and column.
- R8: A write issues the write command with `dramWdata` equal to the request data. Later reads of that location return that data, including after the row has been closed and reopened.
- R9: `reqReady` drops in the cycle after acceptance and returns one cycle after completion: the `rspValid` cycle for a read, `T_CAS` cycles after the write command for a write. Requests presented while `reqReady` is low are ignored.
- R10: At most one of `cmdAct`, `cmdPre`, `cmdRd`, `cmdWr` is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Client request present |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ROW_W+COL_W | Row field in upper bits, column field in lower bits |
| reqWdata | input | SLICE_W | Write slice |
| rspValid | output | 1 | Read data valid, one-cycle pulse |
| rspRdata | output | SLICE_W | Read slice |
| cmdAct | output | 1 | Open-row command |
| cmdPre | output | 1 | Close-row command |
| cmdRd | output | 1 | Column read command |
| cmdWr | output | 1 | Column write command |
| dramAddr | output | max(ROW_W,COL_W) | Shared row/column address |
| dramWdata | output | SLICE_W | Write slice toward the bank |
| dramRdata | input | SLICE_W | Read slice from the bank |

## Verification
The bench builds the block with 4-bit rows, 3-bit columns and 8-bit slices. It uses three different gap values: `T_RP`=4, `T_RCD`=3 and `T_CAS`=2. Because the gaps differ, a counter loaded with the wrong gap moves a command to a cycle the bench does not expect. The small address space lets a short run reach row hits, row conflicts, write-back across a close and reopen, and a reset with a row open. A requirement can be met only because all three gaps share one value, and these settings keep that from happening.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PRE_W,
    ST_ACT,
    ST_ACT_W,
    ST_COL,
    ST_COL_W,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    WAIT_RP,
    WAIT_RCD,
    WAIT_CAS
  } waitSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     takeReq;     // latch client request
    logic     markOpen;    // record latched row as open
    logic     markClosed;  // forget open row
    logic     cntLoad;     // load gap counter
    waitSel_t cntSel;      // which gap to load
    logic     cntDec;      // decrement gap counter
    logic     showCol;     // address bus carries column
    logic     grabRd;      // capture read slice
  } seqStrobe_t;

endpackage

// File: rtl/dram_seq_datapath.sv
module dram_seq_datapath
  import dram_seq_pkg::*;
#(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 3,
  parameter int SLICE_W = 8,
  parameter int T_RCD   = 3,
  parameter int T_CAS   = 2,
  parameter int T_RP    = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             stb,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic                   reqWrite,
  input  logic [SLICE_W-1:0]     reqWdata,
  input  logic [SLICE_W-1:0]     dramRdata,
  output logic                   rowOpen,
  output logic                   rowHit,
  output logic                   cntDone,
  output logic                   curWrite,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic [SLICE_W-1:0]     dramWdata,
  output logic [SLICE_W-1:0]     rspRdata
);

  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_MAX  = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                          : ((T_CAS > T_RP) ? T_CAS : T_RP);
  localparam int CNT_W  = $clog2(T_MAX) + 1;

  logic [ROW_W-1:0]   reqRowQ;
  logic [COL_W-1:0]   reqColQ;
  logic               reqWrQ;
  logic [SLICE_W-1:0] reqDataQ;
  logic [ROW_W-1:0]   openRowQ;
  logic               openValidQ;
  logic [CNT_W-1:0]   cntQ;
  logic [CNT_W-1:0]   loadVal;
  logic [SLICE_W-1:0] rdataQ;
  logic [ROW_W-1:0]   inRow;

  assign inRow = reqAddr[COL_W +: ROW_W];

  // Request latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqRowQ  <= '0;
      reqColQ  <= '0;
      reqWrQ   <= 1'b0;
      reqDataQ <= '0;
    end else if (stb.takeReq) begin
      reqRowQ  <= inRow;
      reqColQ  <= reqAddr[COL_W-1:0];
      reqWrQ   <= reqWrite;
      reqDataQ <= reqWdata;
    end
  end

  // Open-row tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openRowQ   <= '0;
      openValidQ <= 1'b0;
    end else if (stb.markOpen) begin
      openRowQ   <= reqRowQ;
      openValidQ <= 1'b1;
    end else if (stb.markClosed) begin
      openValidQ <= 1'b0;
    end
  end

  assign rowOpen = openValidQ;
  assign rowHit  = openValidQ && (openRowQ == inRow);

  // Gap counter: loaded with gap-2, since the issuing cycle and the final
  // wait cycle are both part of the gap.
  always_comb begin
    case (stb.cntSel)
      WAIT_RP:  loadVal = CNT_W'(T_RP - 2);
      WAIT_RCD: loadVal = CNT_W'(T_RCD - 2);
      default:  loadVal = CNT_W'(T_CAS - 2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (stb.cntLoad) cntQ <= loadVal;
    else if (stb.cntDec)  cntQ <= cntQ - 1'b1;
  end

  assign cntDone = (cntQ == '0);

  // Read capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdataQ <= '0;
    else if (stb.grabRd) rdataQ <= dramRdata;
  end

  assign curWrite  = reqWrQ;
  assign dramAddr  = stb.showCol ? ADDR_W'(reqColQ) : ADDR_W'(reqRowQ);
  assign dramWdata = reqDataQ;
  assign rspRdata  = rdataQ;

endmodule

// File: rtl/dram_seq_control.sv
module dram_seq_control
  import dram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rowOpen,
  input  logic       rowHit,
  input  logic       cntDone,
  input  logic       curWrite,
  output seqStrobe_t stb,
  output logic       reqReady,
  output logic       cmdAct,
  output logic       cmdPre,
  output logic       cmdRd,
  output logic       cmdWr,
  output logic       rspValid
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    stb    = '{takeReq: 1'b0, markOpen: 1'b0, markClosed: 1'b0,
               cntLoad: 1'b0, cntSel: WAIT_CAS, cntDec: 1'b0,
               showCol: 1'b0, grabRd: 1'b0};
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          stb.takeReq = 1'b1;
          if (rowHit)       stateD = ST_COL;
          else if (rowOpen) stateD = ST_PRE;
          else              stateD = ST_ACT;
        end
      end
      ST_PRE: begin
        stb.markClosed = 1'b1;
        stb.cntLoad    = 1'b1;
        stb.cntSel     = WAIT_RP;
        stateD         = ST_PRE_W;
      end
      ST_PRE_W: begin
        if (cntDone) stateD = ST_ACT;
        else         stb.cntDec = 1'b1;
      end
      ST_ACT: begin
        stb.markOpen = 1'b1;
        stb.cntLoad  = 1'b1;
        stb.cntSel   = WAIT_RCD;
        stateD       = ST_ACT_W;
      end
      ST_ACT_W: begin
        if (cntDone) stateD = ST_COL;
        else         stb.cntDec = 1'b1;
      end
      ST_COL: begin
        stb.showCol = 1'b1;
        stb.cntLoad = 1'b1;
        stb.cntSel  = WAIT_CAS;
        stateD      = ST_COL_W;
      end
      ST_COL_W: begin
        if (cntDone) begin
          stb.grabRd = !curWrite;
          stateD     = ST_DONE;
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign cmdPre   = (stateQ == ST_PRE);
  assign cmdAct   = (stateQ == ST_ACT);
  assign cmdRd    = (stateQ == ST_COL) && !curWrite;
  assign cmdWr    = (stateQ == ST_COL) &&  curWrite;
  assign rspValid = (stateQ == ST_DONE) && !curWrite;

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 3,
  parameter int SLICE_W = 8,
  parameter int T_RCD   = 3,
  parameter int T_CAS   = 2,
  parameter int T_RP    = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [SLICE_W-1:0]     reqWdata,
  output logic                   rspValid,
  output logic [SLICE_W-1:0]     rspRdata,
  output logic                   cmdAct,
  output logic                   cmdPre,
  output logic                   cmdRd,
  output logic                   cmdWr,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic [SLICE_W-1:0]     dramWdata,
  input  logic [SLICE_W-1:0]     dramRdata
);

  if (!(SLICE_W == 4 || SLICE_W == 8 || SLICE_W == 16 || SLICE_W == 32)) begin : g_badSlice
    $error("SLICE_W must be 4, 8, 16 or 32");
  end
  if (T_RCD < 2 || T_CAS < 2 || T_RP < 2) begin : g_badGap
    $error("gap parameters must be at least 2 cycles");
  end

  seqStrobe_t stb;
  logic rowOpen, rowHit, cntDone, curWrite;

  dram_seq_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rowOpen  (rowOpen),
    .rowHit   (rowHit),
    .cntDone  (cntDone),
    .curWrite (curWrite),
    .stb      (stb),
    .reqReady (reqReady),
    .cmdAct   (cmdAct),
    .cmdPre   (cmdPre),
    .cmdRd    (cmdRd),
    .cmdWr    (cmdWr),
    .rspValid (rspValid)
  );

  dram_seq_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .SLICE_W(SLICE_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .dramRdata (dramRdata),
    .rowOpen   (rowOpen),
    .rowHit    (rowHit),
    .cntDone   (cntDone),
    .curWrite  (curWrite),
    .dramAddr  (dramAddr),
    .dramWdata (dramWdata),
    .rspRdata  (rspRdata)
  );

endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk #(
  parameter int T_RCD = 3,
  parameter int T_CAS = 2,
  parameter int T_RP  = 4
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic rspValid,
  input logic cmdAct,
  input logic cmdPre,
  input logic cmdRd,
  input logic cmdWr
);

  logic [15:0] sincePre, sinceAct, sinceCol;
  logic        preArmed, actArmed, rdArmed, openSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sincePre <= '0; sinceAct <= '0; sinceCol <= '0;
      preArmed <= 1'b0; actArmed <= 1'b0; rdArmed <= 1'b0; openSeen <= 1'b0;
    end else begin
      sincePre <= cmdPre ? 16'd1 : ((sincePre != 16'hFFFF) ? sincePre + 16'd1 : sincePre);
      sinceAct <= cmdAct ? 16'd1 : ((sinceAct != 16'hFFFF) ? sinceAct + 16'd1 : sinceAct);
      sinceCol <= (cmdRd || cmdWr) ? 16'd1 : ((sinceCol != 16'hFFFF) ? sinceCol + 16'd1 : sinceCol);
      if (cmdPre)      preArmed <= 1'b1;
      else if (cmdAct) preArmed <= 1'b0;
      if (cmdAct)               actArmed <= 1'b1;
      else if (cmdRd || cmdWr)  actArmed <= 1'b0;
      if (cmdRd)         rdArmed <= 1'b1;
      else if (rspValid) rdArmed <= 1'b0;
      if (cmdAct)      openSeen <= 1'b1;
      else if (cmdPre) openSeen <= 1'b0;
    end
  end

  a_r10_one_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdAct, cmdPre, cmdRd, cmdWr}));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(cmdAct || cmdPre || cmdRd || cmdWr || rspValid));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r5_pre_to_act: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAct && preArmed) |-> (sincePre == 16'(T_RP)));

  a_r5_no_double_open: assert property (@(posedge clk) disable iff (!rstN)
    cmdAct |-> !openSeen);

  a_r3_act_to_col: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdRd || cmdWr) && actArmed) |-> (sinceAct == 16'(T_RCD)));

  a_r4_col_needs_open: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRd || cmdWr) |-> openSeen);

  a_r7_rsp_timing: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rdArmed && sinceCol == 16'(T_CAS)));

  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

bind dram_bank_seq dram_bank_seq_chk #(
  .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .cmdAct   (cmdAct),
  .cmdPre   (cmdPre),
  .cmdRd    (cmdRd),
  .cmdWr    (cmdWr)
);

// File: tb/test_dram_bank_seq.sv
module test_dram_bank_seq;

  localparam int ROW_W = 4, COL_W = 3, SLICE_W = 8;
  localparam int T_RCD = 3, T_CAS = 2, T_RP = 4;
  localparam int KIND_HIT = 0, KIND_CLOSED = 1, KIND_CONFLICT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ROW_W+COL_W-1:0] reqAddr = '0;
  logic [SLICE_W-1:0] reqWdata = '0;
  logic reqReady, rspValid, cmdAct, cmdPre, cmdRd, cmdWr;
  logic [SLICE_W-1:0] rspRdata, dramWdata, dramRdata;
  logic [3:0] dramAddr;

  int vectors = 0, miscompares = 0, protoErr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_bank_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .SLICE_W(SLICE_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
  ) i_dram_bank_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .cmdAct(cmdAct),
    .cmdPre(cmdPre), .cmdRd(cmdRd), .cmdWr(cmdWr), .dramAddr(dramAddr),
    .dramWdata(dramWdata), .dramRdata(dramRdata)
  );

  // Behavioural bank
  logic [SLICE_W-1:0] bankMem [16][8];
  logic [SLICE_W-1:0] refMem  [16][8];
  logic               modelOpen;
  logic [3:0]         modelRow;
  logic [2:0]         rdCol;

  assign dramRdata = bankMem[modelRow][rdCol];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelOpen <= 1'b0;
      modelRow  <= '0;
      rdCol     <= '0;
    end else begin
      if (cmdAct) begin
        if (modelOpen) protoErr++;
        modelOpen <= 1'b1;
        modelRow  <= dramAddr;
      end
      if (cmdPre) modelOpen <= 1'b0;
      if (cmdRd) begin
        if (!modelOpen) protoErr++;
        rdCol <= dramAddr[2:0];
      end
      if (cmdWr) begin
        if (!modelOpen) protoErr++;
        bankMem[modelRow][dramAddr[2:0]] <= dramWdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic printSummary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // One request, checked cycle by cycle. With hold set, a different write is
  // presented throughout the busy window and dropped before it can be taken.
  task automatic runReq(input bit wr, input int row, input int col,
                        input logic [7:0] data, input int kind, input bit hold);
    int preAt, actAt, colAt, endAt, readyAt;
    preAt = (kind == KIND_CONFLICT) ? 1 : -1;
    actAt = (kind == KIND_CLOSED) ? 1 : ((kind == KIND_CONFLICT) ? 1 + T_RP : -1);
    colAt = (kind == KIND_HIT) ? 1 : actAt + T_RCD;
    endAt = colAt + T_CAS;
    readyAt = endAt + 1;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr;
    reqAddr = {4'(row), 3'(col)}; reqWdata = data;
    chk(reqReady == 1'b1, "R9", "ready before accept", int'(reqReady), 1);
    @(negedge clk);
    if (hold) begin
      reqWrite = 1'b1; reqAddr = {4'(row), 3'(col ^ 1)}; reqWdata = 8'hEE;
    end else begin
      reqValid = 1'b0;
    end
    for (int k = 1; k <= readyAt; k++) begin
      chk($countones({cmdAct, cmdPre, cmdRd, cmdWr}) <= 1, "R10", "one command",
          $countones({cmdAct, cmdPre, cmdRd, cmdWr}), 1);
      chk(cmdPre == (k == preAt), "R5", $sformatf("close strobe k=%0d", k),
          int'(cmdPre), int'(k == preAt));
      chk(cmdAct == (k == actAt), (kind == KIND_CLOSED) ? "R2" : "R5",
          $sformatf("open strobe k=%0d", k), int'(cmdAct), int'(k == actAt));
      chk(cmdRd == (!wr && k == colAt), (kind == KIND_HIT) ? "R4" : "R3",
          $sformatf("read strobe k=%0d", k), int'(cmdRd), int'(!wr && k == colAt));
      chk(cmdWr == (wr && k == colAt), (kind == KIND_HIT) ? "R4" : "R3",
          $sformatf("write strobe k=%0d", k), int'(cmdWr), int'(wr && k == colAt));
      chk(rspValid == (!wr && k == endAt), "R7", $sformatf("rspValid k=%0d", k),
          int'(rspValid), int'(!wr && k == endAt));
      chk(reqReady == (k == readyAt), "R9", $sformatf("ready k=%0d", k),
          int'(reqReady), int'(k == readyAt));
      if (k == actAt)
        chk(dramAddr == 4'(row), "R2", "row on address bus", int'(dramAddr), row);
      if (k == colAt) begin
        chk(dramAddr == 4'(col), "R6", "column on address bus", int'(dramAddr), col);
        if (wr) chk(dramWdata == data, "R8", "write slice", int'(dramWdata), int'(data));
      end
      if (k == endAt && !wr)
        chk(rspRdata == refMem[row][col], "R7", "read slice",
            int'(rspRdata), int'(refMem[row][col]));
      if (k == readyAt) reqValid = 1'b0;
      else @(negedge clk);
    end
    if (wr) refMem[row][col] = data;
    if (hold) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!(cmdAct || cmdPre || cmdRd || cmdWr), "R9", "no command from ignored request",
            int'({cmdAct, cmdPre, cmdRd, cmdWr}), 0);
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "ready in reset", int'(reqReady), 1);
    chk(rspValid == 1'b0, "R1", "rspValid in reset", int'(rspValid), 0);
    chk({cmdAct, cmdPre, cmdRd, cmdWr} == 4'b0, "R1", "commands in reset",
        int'({cmdAct, cmdPre, cmdRd, cmdWr}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && !rspValid && !(cmdAct || cmdPre || cmdRd || cmdWr),
        "R1", "idle after reset", int'({reqReady, rspValid, cmdAct, cmdPre, cmdRd, cmdWr}), 32);
  endtask

  task automatic testMidReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk(reqReady == 1'b1, "R1", "ready after second reset", int'(reqReady), 1);
    runReq(1'b0, 9, 3, 8'h00, KIND_CLOSED, 1'b0);   // R2: open row lost, no close issued
  endtask

  initial begin
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++) begin
        bankMem[r][c] = 8'(r * 16 + c + 3);
        refMem[r][c]  = 8'(r * 16 + c + 3);
      end
    repeat (3) @(negedge clk);
    testReset();                                     // R1
    runReq(1'b0, 5, 2, 8'h00, KIND_CLOSED,   1'b0);  // R2 R3 R7
    runReq(1'b0, 5, 6, 8'h00, KIND_HIT,      1'b0);  // R4 R6
    runReq(1'b1, 5, 1, 8'hA5, KIND_HIT,      1'b0);  // R8 write hit
    runReq(1'b0, 5, 1, 8'h00, KIND_HIT,      1'b0);  // R8 read back
    runReq(1'b0, 9, 0, 8'h00, KIND_CONFLICT, 1'b0);  // R5
    runReq(1'b1, 2, 7, 8'h5A, KIND_CONFLICT, 1'b0);  // R5 R8 write conflict
    runReq(1'b0, 2, 7, 8'h00, KIND_HIT,      1'b0);  // R8
    runReq(1'b0, 2, 3, 8'h00, KIND_HIT,      1'b1);  // R9 ignored while busy
    runReq(1'b0, 2, 2, 8'h00, KIND_HIT,      1'b0);  // R9 col 2 untouched by ignored write
    runReq(1'b0, 5, 1, 8'h00, KIND_CONFLICT, 1'b0);  // R8 survives close/reopen
    testMidReset();                                  // R1 R2
    chk(protoErr == 0, "R5", "bank protocol violations", protoErr, 0);
    done = 1;
    printSummary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      printSummary();
      $finish;
    end
  end

endmodule